// File: doc/BRIEF.md
# Power-Down Entry and Wake Controller

This controller sits beside a small microcontroller core and decides when the core may drop into a low-power state in which the oscillator is halted but RAM keeps its contents. Software reaches that state with a two-instruction sequence: a preparatory "arm" instruction, then a "power-off" instruction as the next executed instruction. A power-off on its own does nothing, so a stray or mis-decoded power-off cannot halt the part.

The controller keeps a power-down flag that survives the retention state. When the synchronized external wakeup arrives, the controller releases the oscillator, requests a core restart at page 0, address 0, and sets the flag (warm start). When a reset pin pulse, a watchdog reset or a supply-drop detection arrives, it requests the same restart but clears the flag (cold start). Start-up code runs a flag-test instruction, which raises a one-cycle skip strobe when the flag is set, and branches to warm or cold initialisation. On entry the controller also strobes a stack-pointer preset to the value 7.

Top module: `pdn_wake_ctrl`

## Requirements
- R1: While running, an executed power-off instruction whose previous executed instruction was the arm instruction makes `osc_stop_o` and `retain_o` go to 1 at the next rising clock edge.
- R2: A power-off instruction whose previous executed instruction was not the arm instruction has no effect: `osc_stop_o` stays 0.
- R3: On the edge that enters retention, `sp_preset_o` is 1 for exactly that one cycle; `sp_value_o` is always 7 (SP_W = 3).
- R4: In retention, `wake_i` passes through a two-flop synchronizer; with `wake_i` raised before edge 1 and held, `restart_o` is 1 and `osc_stop_o` is 0 after edge 3, the flag becomes 1, and `restart_vec_o` is 0 (page 0, address 0).
- R5: Any of `ext_rst_i`, `wdt_rst_i`, `vdrop_i` high at an edge gives `restart_o` = 1, `osc_stop_o` = 0 and flag = 0 after that edge, whether running or retained.
- R6: In retention, a reset source at the same edge as the synchronized wakeup wins: the restart is cold and the flag is 0.
- R7: A flag-test instruction while running gives `skip_o` = 1 for one cycle after the edge if the flag is 1, and 0 if the flag is 0.
- R8: Cycles with `instr_valid_i` = 0 do not break the arm-then-power-off pairing; any reset source clears the arm condition.
- R9: `wake_i` while running produces no restart.
- R10: After `rst_n` low, all outputs other than `sp_value_o` are 0 and the flag is 0.
- R11: While retained, instructions are ignored: no skip, no restart, the state is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on controller clock |
| rst_n | input | 1 | Asynchronous active-low controller reset |
| instr_valid_i | input | 1 | An instruction is executed this cycle |
| op_arm_i | input | 1 | Executed instruction is the arm instruction |
| op_pwroff_i | input | 1 | Executed instruction is the power-off instruction |
| op_test_i | input | 1 | Executed instruction is the flag test |
| wake_i | input | 1 | Asynchronous external wakeup |
| ext_rst_i | input | 1 | Reset pin pulse (synchronous) |
| wdt_rst_i | input | 1 | Watchdog reset |
| vdrop_i | input | 1 | Supply-drop detection |
| osc_stop_o | output | 1 | Halt the core oscillator |
| retain_o | output | 1 | Controller is in the retention state |
| restart_o | output | 1 | One-cycle core restart request |
| restart_vec_o | output | 11 | Restart address {page, address} |
| sp_preset_o | output | 1 | Load the stack pointer with `sp_value_o` |
| sp_value_o | output | 3 | Stack-pointer preset value |
| skip_o | output | 1 | Skip result of the flag test |

## Verification
The bench breaks the arm pairing in each way that matters: a lone power-off, a non-arm instruction in between, and a reset source in between; a design that only looked for an arm at any earlier time would halt the oscillator in those cases. It also places idle cycles inside the pairing, which a design counting clock cycles rather than executed instructions would wrongly reject. The wakeup is timed to the third edge, so a missing or extra synchronizer stage shows as an early or late restart, and a reset source is aligned with the synchronized wakeup, where a design giving wakeup priority would leave the flag set and the flag test would skip.

// File: rtl/pdn_pkg.sv
package pdn_pkg;

    typedef enum logic {
        PD_RUN    = 1'b0,
        PD_RETAIN = 1'b1
    } pd_state_e;

    typedef struct packed {
        pd_state_e state;
        logic      flag;
        logic      osc_stop;
        logic      restart;
        logic      sp_preset;
        logic      skip;
    } pd_core_regs_t;

endpackage

// File: rtl/pdn_arm_seq.sv
module pdn_arm_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid_i,
    input  logic op_arm_i,
    input  logic retain_i,
    input  logic rst_src_i,
    output logic arm_o
);

    logic arm_d, arm_q;

    always_comb begin
        arm_d = arm_q;
        if (rst_src_i) begin
            arm_d = 1'b0;
        end else if (instr_valid_i && !retain_i) begin
            arm_d = op_arm_i;
        end else if (retain_i) begin
            arm_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) arm_q <= 1'b0;
        else        arm_q <= arm_d;
    end

    assign arm_o = arm_q;

    assert_arm_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_src_i |=> !arm_q);

    assert_arm_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!instr_valid_i && !rst_src_i && !retain_i) |=> (arm_q == $past(arm_q)));

endmodule

// File: rtl/pdn_wake_sync.sv
module pdn_wake_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wake_raw_i,
    output logic wake_s_o
);

    logic [STAGES-1:0] sync_d, sync_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sync_d = wake_raw_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[STAGES-2:0], wake_raw_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign wake_s_o = sync_q[STAGES-1];

    assert_sync_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_s_o) |-> $past(sync_d[STAGES-1]));

endmodule

// File: rtl/pdn_state_core.sv
module pdn_state_core
    import pdn_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic instr_valid_i,
    input  logic op_pwroff_i,
    input  logic op_test_i,
    input  logic arm_i,
    input  logic wake_s_i,
    input  logic rst_src_i,
    output logic retain_o,
    output logic osc_stop_o,
    output logic restart_o,
    output logic sp_preset_o,
    output logic skip_o
);

    pd_core_regs_t regs_d, regs_q;
    logic          entry_req;

    assign entry_req = instr_valid_i && op_pwroff_i && arm_i;

    always_comb begin
        regs_d           = regs_q;
        regs_d.restart   = 1'b0;
        regs_d.sp_preset = 1'b0;
        regs_d.skip      = 1'b0;
        if (rst_src_i) begin
            regs_d.state    = PD_RUN;
            regs_d.flag     = 1'b0;
            regs_d.osc_stop = 1'b0;
            regs_d.restart  = 1'b1;
        end else begin
            unique case (regs_q.state)
                PD_RUN: begin
                    if (entry_req) begin
                        regs_d.state     = PD_RETAIN;
                        regs_d.osc_stop  = 1'b1;
                        regs_d.sp_preset = 1'b1;
                    end else if (instr_valid_i && op_test_i) begin
                        regs_d.skip = regs_q.flag;
                    end
                end
                PD_RETAIN: begin
                    if (wake_s_i) begin
                        regs_d.state    = PD_RUN;
                        regs_d.flag     = 1'b1;
                        regs_d.osc_stop = 1'b0;
                        regs_d.restart  = 1'b1;
                    end
                end
                default: regs_d.state = PD_RUN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: PD_RUN, default: 1'b0};
        else        regs_q <= regs_d;
    end

    assign retain_o    = (regs_q.state == PD_RETAIN);
    assign osc_stop_o  = regs_q.osc_stop;
    assign restart_o   = regs_q.restart;
    assign sp_preset_o = regs_q.sp_preset;
    assign skip_o      = regs_q.skip;

    assert_entry_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == PD_RUN && entry_req && !rst_src_i) |=> (osc_stop_o && retain_o));

    assert_lone_pwroff_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.state == PD_RUN && instr_valid_i && op_pwroff_i && !arm_i) |=> !osc_stop_o);

    assert_sp_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(retain_o) |-> sp_preset_o);

    assert_sp_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sp_preset_o |=> !sp_preset_o);

    assert_warm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (retain_o && wake_s_i && !rst_src_i) |=> (restart_o && regs_q.flag && !osc_stop_o));

    assert_cold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rst_src_i |=> (restart_o && !regs_q.flag && !osc_stop_o));

    assert_reset_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (retain_o && wake_s_i && rst_src_i) |=> !regs_q.flag);

    assert_skip_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        skip_o |-> $past(instr_valid_i && op_test_i && !retain_o));

    assert_run_wake_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!retain_o && !rst_src_i) |=> !restart_o);

    assert_retain_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (retain_o && !wake_s_i && !rst_src_i) |=> (retain_o && !skip_o && !restart_o));

endmodule

// File: rtl/pdn_wake_ctrl.sv
module pdn_wake_ctrl #(
    parameter int PAGE_W      = 4,
    parameter int ADDR_W      = 7,
    parameter int SP_W        = 3,
    parameter int SP_INIT     = 7,
    parameter int SYNC_STAGES = 2,
    localparam int VEC_W      = PAGE_W + ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_valid_i,
    input  logic             op_arm_i,
    input  logic             op_pwroff_i,
    input  logic             op_test_i,
    input  logic             wake_i,
    input  logic             ext_rst_i,
    input  logic             wdt_rst_i,
    input  logic             vdrop_i,
    output logic             osc_stop_o,
    output logic             retain_o,
    output logic             restart_o,
    output logic [VEC_W-1:0] restart_vec_o,
    output logic             sp_preset_o,
    output logic [SP_W-1:0]  sp_value_o,
    output logic             skip_o
);

    localparam logic [PAGE_W-1:0] START_PAGE = '0;
    localparam logic [ADDR_W-1:0] START_ADDR = '0;

    logic rst_src;
    logic arm;
    logic wake_s;

    assign rst_src = ext_rst_i | wdt_rst_i | vdrop_i;

    pdn_arm_seq u_arm (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid_i (instr_valid_i),
        .op_arm_i      (op_arm_i),
        .retain_i      (retain_o),
        .rst_src_i     (rst_src),
        .arm_o         (arm)
    );

    pdn_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .wake_raw_i (wake_i),
        .wake_s_o   (wake_s)
    );

    pdn_state_core u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .instr_valid_i (instr_valid_i),
        .op_pwroff_i   (op_pwroff_i),
        .op_test_i     (op_test_i),
        .arm_i         (arm),
        .wake_s_i      (wake_s),
        .rst_src_i     (rst_src),
        .retain_o      (retain_o),
        .osc_stop_o    (osc_stop_o),
        .restart_o     (restart_o),
        .sp_preset_o   (sp_preset_o),
        .skip_o        (skip_o)
    );

    assign restart_vec_o = {START_PAGE, START_ADDR};
    assign sp_value_o    = SP_W'(SP_INIT);

endmodule

// File: tb/pdn_wake_ctrl_bench.sv
`timescale 1ns/1ps
module pdn_wake_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0, arm = 1'b0, pwr = 1'b0, tst = 1'b0;
    logic        wake = 1'b0, erst = 1'b0, wrst = 1'b0, vdrp = 1'b0;
    logic        osc_stop, retain, restart, sp_preset, skip;
    logic [10:0] vec;
    logic [2:0]  spv;
    int          checks = 0;
    int          failures = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pdn_wake_ctrl u_pdn_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .instr_valid_i(valid), .op_arm_i(arm),
        .op_pwroff_i(pwr), .op_test_i(tst), .wake_i(wake), .ext_rst_i(erst),
        .wdt_rst_i(wrst), .vdrop_i(vdrp), .osc_stop_o(osc_stop), .retain_o(retain),
        .restart_o(restart), .restart_vec_o(vec), .sp_preset_o(sp_preset),
        .sp_value_o(spv), .skip_o(skip)
    );

    // row bits: {valid, arm, pwroff, test, exp_osc, exp_skip, exp_sp}
    localparam logic [6:0] VEC [0:8] = '{
        7'b1001000,  // R7 test with flag 0
        7'b1010000,  // R2 lone power-off
        7'b1100000,  // arm
        7'b1000000,  // other instruction breaks pairing
        7'b1010000,  // R2 power-off after other instruction
        7'b1100000,  // arm
        7'b0000000,  // R8 idle cycle keeps arm
        7'b1010101,  // R1 R3 entry
        7'b1001100   // R11 test ignored in retention
    };

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(logic v, logic a, logic p, logic t);
        @(negedge clk);
        valid = v; arm = a; pwr = p; tst = t;
        @(posedge clk);
        #1;
    endtask

    task automatic enter();
        step(1, 1, 0, 0);
        step(1, 0, 1, 0);
    endtask

    task automatic warm_wake();
        @(negedge clk); valid = 0; arm = 0; pwr = 0; tst = 0; wake = 1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(negedge clk); wake = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R10 osc_stop", osc_stop, 0);
        check("R10 restart", restart, 0);
        check("R10 skip", skip, 0);
        check("R10 sp_preset", sp_preset, 0);
        @(negedge clk); rst_n = 1'b1;

        for (int i = 0; i < 9; i++) begin
            step(VEC[i][6], VEC[i][5], VEC[i][4], VEC[i][3]);
            check($sformatf("R1/R2 row%0d osc", i), osc_stop, VEC[i][2]);
            check($sformatf("R7/R11 row%0d skip", i), skip, VEC[i][1]);
            check($sformatf("R3 row%0d sp", i), sp_preset, VEC[i][0]);
            check($sformatf("R11 row%0d restart", i), restart, 0);
        end
        check("R3 sp value", spv, 7);

        // R4 wake timing: three edges
        @(negedge clk); valid = 0; tst = 0; wake = 1;
        @(posedge clk); #1; check("R4 edge1 restart", restart, 0);
        @(posedge clk); #1; check("R4 edge2 restart", restart, 0);
        check("R4 edge2 osc", osc_stop, 1);
        @(posedge clk); #1; check("R4 edge3 restart", restart, 1);
        check("R4 edge3 osc", osc_stop, 0);
        check("R4 vector", vec, 0);
        @(negedge clk); wake = 0;
        @(posedge clk); #1; check("R4 restart one cycle", restart, 0);

        step(1, 0, 0, 1); check("R7 skip flag1", skip, 1);
        step(0, 0, 0, 0); check("R7 skip one cycle", skip, 0);

        // R9 wake while running
        @(negedge clk); wake = 1;
        repeat (4) begin @(posedge clk); #1; check("R9 no restart", restart, 0); end
        @(negedge clk); wake = 0;
        repeat (3) @(posedge clk);

        // R6 reset source aligned with synchronized wakeup
        enter();
        check("R1 entry", osc_stop, 1);
        @(negedge clk); valid = 0; pwr = 0; wake = 1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        @(negedge clk); vdrp = 1;
        @(posedge clk); #1;
        check("R6 restart", restart, 1);
        check("R6 osc", osc_stop, 0);
        @(negedge clk); vdrp = 0; wake = 0;
        repeat (3) @(posedge clk);
        step(1, 0, 0, 1); check("R6 flag cleared", skip, 0);

        // R5 cold start while running, flag set first
        enter();
        warm_wake();
        step(1, 0, 0, 1); check("R5 pre flag1", skip, 1);
        @(negedge clk); valid = 0; tst = 0; erst = 1;
        @(posedge clk); #1; check("R5 ext restart", restart, 1);
        @(negedge clk); erst = 0;
        step(1, 0, 0, 1); check("R5 ext flag0", skip, 0);

        // R5 watchdog reset in retention
        enter();
        @(negedge clk); valid = 0; pwr = 0; wrst = 1;
        @(posedge clk); #1;
        check("R5 wdt restart", restart, 1);
        check("R5 wdt osc", osc_stop, 0);
        check("R5 wdt retain", retain, 0);
        @(negedge clk); wrst = 0;

        // R8 reset source between arm and power-off
        step(1, 1, 0, 0);
        @(negedge clk); valid = 0; arm = 0; erst = 1;
        @(posedge clk); #1;
        @(negedge clk); erst = 0;
        step(1, 0, 1, 0); check("R8 arm cleared by reset", osc_stop, 0);

        // R10 controller reset returns to idle from retention
        enter();
        @(negedge clk); valid = 0; pwr = 0; rst_n = 0;
        #1; check("R10 reset from retain", osc_stop, 0);
        check("R10 retain", retain, 0);
        @(negedge clk); rst_n = 1;

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule